// File: doc/BRIEF.md
# Stalled-Initiator Lockout Monitor

This block sits beside a bus arbiter and watches the initiator that currently holds the grant. If that initiator has the grant while the bus is idle and does not begin a transaction within a fixed window of idle clocks, the monitor sends a one-cycle grant-removal pulse. It also sets that initiator's bit in a lockout mask. The arbiter uses the mask to disregard the initiator's request line.

The lockout holds only while the offending initiator keeps its request raised. A single clock with the request low clears its mask bit, and after that it competes normally again. A global enable switches the whole function off. While disabled, no grant is ever revoked, every mask bit is cleared, and an initiator keeps its grant until it starts a transaction or lowers its request, which the arbiter handles.

Top module: `lockout_monitor`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `lock_mask` is all zeros and `revoke` is 0.
- R2: With `enable` high, suppose one initiator holds the grant for `WINDOW` (default 16) idle clocks, with no `frame_start` and no change of grant. Counting starts at the first idle clock that has a grant present. On the clock edge of the last of those idle clocks, `revoke` goes high for exactly one cycle. On the same edge, mask bit i is set, where bit i belongs to the initiator whose grant bit i was high. After `WINDOW`-1 such clocks, nothing fires.
- R3: A clock with `frame_start` high clears the idle count. A full new window of idle clocks is then needed before a timeout, and a clock with `frame_start` high never produces a `revoke` on its edge.
- R4: The idle count restarts when the grant moves to another initiator or drops to all zeros.
- R5: A clock where `bus_idle` is low and `frame_start` is low neither advances nor clears the idle count.
- R6: A set mask bit stays set while that initiator's request is high. It clears on the edge where its request is sampled low, so a request raised on the following clock is not masked.
- R7: While the granted initiator's mask bit is set, no further `revoke` is produced.
- R8: While `enable` is low, `revoke` stays 0, every mask bit is cleared on the next edge, and the idle count is held at zero.
- R9: Mask bits of different initiators are set and cleared independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the lockout function on |
| grant | input | N_INIT | One-hot (or zero) grant vector from the arbiter |
| req | input | N_INIT | Request line of each initiator |
| frame_start | input | 1 | High on a clock where a transaction begins |
| bus_idle | input | 1 | High on a clock where the bus is idle |
| lock_mask | output | N_INIT | Bit i set: initiator i's request must be ignored |
| revoke | output | 1 | One-cycle pulse: remove the current grant |

## Verification
A wrong idle count shows up as a `revoke` pulse one or more clocks early or late relative to the 16th idle clock, or as a missing pulse. The bench therefore samples the pulse on the exact clock of the window boundary and on the clock before it. A stuck or wrongly cleared mask bit shows at `lock_mask` on the clock after the request is sampled low. A missing suppression shows as a second pulse while the locked initiator still holds the grant, which appears one window later.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
    localparam int unsigned LKO_DEF_INITS  = 4;
    localparam int unsigned LKO_DEF_WINDOW = 16;

    function automatic int unsigned lko_cnt_width(input int unsigned window);
        return $clog2(window + 1);
    endfunction
endpackage

// File: rtl/lockout_window_timer.sv
module lockout_window_timer
    import lockout_pkg::*;
#(
    parameter int unsigned N_INIT = LKO_DEF_INITS,
    parameter int unsigned WINDOW = LKO_DEF_WINDOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [N_INIT-1:0] grant,
    input  logic              suppress,
    input  logic              frame_start,
    input  logic              bus_idle,
    output logic              expire
);
    localparam int unsigned CW = lko_cnt_width(WINDOW);

    typedef struct packed {
        logic [N_INIT-1:0] gnt;
        logic [CW-1:0]     cnt;
    } timer_t;

    timer_t st_d, st_q;
    logic          held;
    logic [CW-1:0] base;

    always_comb begin
        held   = (grant == st_q.gnt) && (|grant);
        base   = held ? st_q.cnt : '0;
        st_d   = st_q;
        st_d.gnt = grant;
        st_d.cnt = base;
        expire = 1'b0;
        if (!enable || !(|grant) || frame_start || suppress) begin
            st_d.cnt = '0;
        end else if (bus_idle) begin
            if (base == CW'(WINDOW - 1)) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = base + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lockout_mask_bank.sv
module lockout_mask_bank
    import lockout_pkg::*;
#(
    parameter int unsigned N_INIT = LKO_DEF_INITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [N_INIT-1:0] set_vec,
    input  logic [N_INIT-1:0] req,
    output logic [N_INIT-1:0] mask
);
    logic [N_INIT-1:0] mask_d, mask_q;

    for (genvar i = 0; i < N_INIT; i++) begin : g_bit
        always_comb begin
            mask_d[i] = enable && (set_vec[i] || (mask_q[i] && req[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/lockout_monitor.sv
module lockout_monitor
    import lockout_pkg::*;
#(
    parameter int unsigned N_INIT = LKO_DEF_INITS,
    parameter int unsigned WINDOW = LKO_DEF_WINDOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [N_INIT-1:0] grant,
    input  logic [N_INIT-1:0] req,
    input  logic              frame_start,
    input  logic              bus_idle,
    output logic [N_INIT-1:0] lock_mask,
    output logic              revoke
);
    logic              expire;
    logic              suppress;
    logic [N_INIT-1:0] set_vec;
    logic              revoke_d, revoke_q;

    always_comb begin
        suppress = |(grant & lock_mask);
        set_vec  = expire ? grant : '0;
        revoke_d = expire;
    end

    lockout_window_timer #(.N_INIT(N_INIT), .WINDOW(WINDOW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .grant       (grant),
        .suppress    (suppress),
        .frame_start (frame_start),
        .bus_idle    (bus_idle),
        .expire      (expire)
    );

    lockout_mask_bank #(.N_INIT(N_INIT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .set_vec (set_vec),
        .req     (req),
        .mask    (lock_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) revoke_q <= 1'b0;
        else        revoke_q <= revoke_d;
    end

    assign revoke = revoke_q;
endmodule

// File: rtl/lockout_monitor_checker.sv
module lockout_monitor_checker #(
    parameter int unsigned N_INIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [N_INIT-1:0] grant,
    input logic [N_INIT-1:0] req,
    input logic              frame_start,
    input logic              bus_idle,
    input logic [N_INIT-1:0] lock_mask,
    input logic              revoke
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        revoke |=> !revoke);

    a_r2_one_new_lock: assert property (@(posedge clk) disable iff (!rst_n)
        revoke |-> ($countones(lock_mask & ~$past(lock_mask)) == 1));

    a_r9_lock_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lock_mask & ~$past(lock_mask))) |-> revoke);

    a_r3_frame_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !revoke);

    a_r6_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lock_mask & ~req)) |=> (revoke || ((lock_mask & $past(lock_mask & ~req)) == '0)));

    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & lock_mask)) |=> !revoke);

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((lock_mask == '0) && !revoke));

    a_r5_idle_gap_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && !frame_start && !$past(revoke)) |=> !revoke || $past(bus_idle));
endmodule

bind lockout_monitor lockout_monitor_checker #(.N_INIT(N_INIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .grant       (grant),
    .req         (req),
    .frame_start (frame_start),
    .bus_idle    (bus_idle),
    .lock_mask   (lock_mask),
    .revoke      (revoke)
);

// File: tb/lockout_monitor_test.sv
module lockout_monitor_test;
    localparam int NI = 4;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [NI-1:0] grant = '0;
    logic [NI-1:0] req = '0;
    logic          frame_start = 1'b0;
    logic          bus_idle = 1'b0;
    logic [NI-1:0] lock_mask;
    logic          revoke;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lockout_monitor #(.N_INIT(NI), .WINDOW(16)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .grant(grant), .req(req),
        .frame_start(frame_start), .bus_idle(bus_idle),
        .lock_mask(lock_mask), .revoke(revoke)
    );

    // row: rep[23:16] en[15] gnt[14:11] req[10:7] frame[6] idle[5] mask[4:1] rev[0]
    localparam logic [23:0] VEC [NV] = '{
        {8'd1,  1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0}, // R1
        {8'd15, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 4'b0000, 1'b0}, // R2 one short
        {8'd1,  1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 4'b0001, 1'b1}, // R2 fires
        {8'd1,  1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 4'b0001, 1'b0}, // R2 pulse ends
        {8'd20, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 4'b0001, 1'b0}, // R7
        {8'd1,  1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0}, // R6
        {8'd10, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b1, 4'b0000, 1'b0}, // R3 partial
        {8'd1,  1'b1, 4'b0010, 4'b0010, 1'b1, 1'b0, 4'b0000, 1'b0}, // R3 frame
        {8'd15, 1'b1, 4'b0010, 4'b0010, 1'b0, 1'b1, 4'b0000, 1'b0}, // R3 restart
        {8'd5,  1'b1, 4'b0010, 4'b0010, 1'b0, 1'b0, 4'b0000, 1'b0}, // R5 hold
        {8'd1,  1'b1, 4'b0010, 4'b0010, 1'b0, 1'b1, 4'b0010, 1'b1}, // R5 fires
        {8'd15, 1'b1, 4'b0100, 4'b0110, 1'b0, 1'b1, 4'b0010, 1'b0}, // R4 / R9
        {8'd1,  1'b1, 4'b1000, 4'b1110, 1'b0, 1'b1, 4'b0010, 1'b0}, // R4 moved
        {8'd14, 1'b1, 4'b1000, 4'b1110, 1'b0, 1'b1, 4'b0010, 1'b0}, // R4
        {8'd1,  1'b1, 4'b1000, 4'b1110, 1'b0, 1'b1, 4'b1010, 1'b1}, // R9
        {8'd1,  1'b0, 4'b0001, 4'b1111, 1'b0, 1'b1, 4'b0000, 1'b0}, // R8
        {8'd30, 1'b0, 4'b0001, 4'b1111, 1'b0, 1'b1, 4'b0000, 1'b0}, // R8
        {8'd16, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 4'b0001, 1'b1}  // R8 re-enabled
    };

    task automatic check(input string tag, input logic [NI-1:0] exp_m, input logic exp_r);
        n_chk++;
        if (lock_mask !== exp_m || revoke !== exp_r) begin
            n_bad++;
            $display("FAIL %s: mask=%b revoke=%b expected mask=%b revoke=%b",
                     tag, lock_mask, revoke, exp_m, exp_r);
        end
    endtask

    task automatic step(input logic en, input logic [NI-1:0] g, input logic [NI-1:0] r,
                        input logic fr, input logic idl, input int rep);
        for (int k = 0; k < rep; k++) begin
            @(negedge clk);
            enable = en; grant = g; req = r; frame_start = fr; bus_idle = idl;
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #1;
        check("R1 in reset", '0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", '0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][15], VEC[v][14:11], VEC[v][10:7], VEC[v][6], VEC[v][5],
                 int'(VEC[v][23:16]));
            check($sformatf("vector %0d", v), VEC[v][4:1], VEC[v][0]);
        end

        // R6: request low one clock clears, request high next clock is honoured
        step(1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 1);
        check("R6 cleared", 4'b0000, 1'b0);
        step(1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 1);
        check("R6 re-request not masked", 4'b0000, 1'b0);

        // R4: grant dropping to zero restarts the count (count is 1 here)
        step(1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 9);
        step(1'b1, 4'b0000, 4'b0001, 1'b0, 1'b1, 1);
        step(1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 15);
        check("R4 zero grant restarts", 4'b0000, 1'b0);
        step(1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 1);
        check("R4 full window after restart", 4'b0001, 1'b1);

        // R1: reset in the middle of a lockout
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 released again", '0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule